// File: doc/BRIEF.md
# Halfword-Swapping DMA Data Path

This block sits between a peripheral with a 16-bit bus and the memory side of a DMA channel. The peripheral issues one request at a time: an address, a byte length, a direction and a pass-through flag. The block combines the request address with a base value from a configuration input. It then issues memory bursts and streams the data one byte per handshake in the requested direction. Bytes for writes come from the peripheral and go to memory. Bytes for reads come from memory and go back to the peripheral.

With the pass-through flag set, bytes travel unchanged, and the request's own address and length are used as given. With the flag clear, the block works on 16-bit halfwords. It forces the address and the length even, and it exchanges the two bytes of every halfword in both directions. Swapped writes are cut into bursts of bounded size. Each burst starts where the previous one ended. A single-cycle completion pulse ends every request, including one left with nothing to move.

Top module: `hsdma_path`

## Requirements
- R1: The address of the first memory burst equals `req_addr | cfg_base`, bitwise OR and not a sum, with bit 0 then cleared when `req_pass` is 0. The burst fields stay stable while `mem_cmd_valid` is high and `mem_cmd_ready` is low.
- R2: With `req_pass` = 1, the burst address keeps bit 0, the length is `req_len` unchanged, and byte k of the source stream is byte k of the destination stream.
- R3: With `req_pass` = 0, every burst has address bit 0 and length bit 0 equal to 0, and exactly `req_len` with bit 0 cleared bytes are moved.
- R4: With `req_pass` = 0 and `req_wr` = 1, source byte k is written to memory as stream byte k XOR 1, so the two bytes of each halfword are exchanged.
- R5: A read (`req_wr` = 0) is issued as one burst of the whole (possibly trimmed) length. The memory bytes return to the peripheral in order, with halfword bytes exchanged when `req_pass` = 0.
- R6: A write with `req_pass` = 0 is split into bursts of at most CHUNK bytes (default 64). Every burst is full except the last one, and each starts at the previous burst's address plus its length.
- R7: A write with `req_pass` = 1 is issued as a single burst of the full length, even when the length exceeds CHUNK.
- R8: A request whose length is 0 after trimming issues no memory burst and moves no data. `done` is high in the cycle after the request is accepted.
- R9: `done` is high for exactly one cycle, and that is the cycle after the last byte of the request is accepted. For writes, this is acceptance on the memory write port; for reads, it is acceptance on the peripheral read port.
- R10: `req_ready` is high only while the block is idle. It is low whenever a burst, a data byte or `done` is pending.
- R11: After reset `req_ready` = 1, while `mem_cmd_valid` = 0, `mem_wvalid` = 0, `rd_valid` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Base value ORed into every request address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | AW | Peripheral request address |
| req_len | input | LW | Request length in bytes |
| req_wr | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_pass | input | 1 | 1: bytes unchanged, 0: halfword byte exchange |
| wdat_valid | input | 1 | Peripheral write byte valid |
| wdat_ready | output | 1 | Peripheral write byte accepted |
| wdat_byte | input | 8 | Peripheral write byte |
| rd_valid | output | 1 | Read byte to peripheral valid |
| rd_ready | input | 1 | Peripheral accepts read byte |
| rd_byte | output | 8 | Read byte to peripheral |
| mem_cmd_valid | output | 1 | Memory burst command valid |
| mem_cmd_ready | input | 1 | Memory accepts burst command |
| mem_cmd_addr | output | AW | Burst start address |
| mem_cmd_len | output | LW | Burst length in bytes |
| mem_cmd_wr | output | 1 | Burst direction, 1 = write |
| mem_wvalid | output | 1 | Memory write byte valid |
| mem_wready | input | 1 | Memory accepts write byte |
| mem_wdata | output | 8 | Memory write byte |
| mem_rvalid | input | 1 | Memory read byte valid |
| mem_rready | output | 1 | Block accepts memory read byte |
| mem_rdata | input | 8 | Memory read byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
A request is taken at the edge where `req_valid` and `req_ready` are both high. Its first burst command appears in the next cycle, and an empty request raises `done` in that same next cycle. `done` always follows the last data handshake of the request by exactly one clock. The bench numbers every rising edge and logs the edge of each handshake and of `done`. It then compares edge numbers (acceptance + 1, last byte + 1), so timing is checked without depending on process order. Command acceptance is throttled in a fixed pattern to exercise the hold rule. All stimulus changes on the falling edge.

// File: rtl/hsdma_pkg.sv
package hsdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_DATA = 2'd2,
      ST_FIN  = 2'd3
   } hsdma_state_e;

endpackage

// File: rtl/hsdma_addr_gen.sv
module hsdma_addr_gen #(
   parameter int AW    = 32,
   parameter int LW    = 16,
   parameter int CHUNK = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   input  logic          req_wr,
   input  logic          req_pass,
   input  logic          advance,
   output logic          zero_len,
   output logic [AW-1:0] cur_addr,
   output logic [LW-1:0] chunk_len,
   output logic          last_chunk,
   output logic          wr_q,
   output logic          pass_q
);

   localparam logic [LW-1:0] CHUNK_L = LW'(CHUNK);

   logic [AW-1:0] merged;
   logic [AW-1:0] trim_addr;
   logic [LW-1:0] trim_len;
   logic [AW-1:0] addr_q;
   logic [LW-1:0] rem_q;
   logic          split;

   // base is merged with OR; in halfword mode both low bits are dropped
   always_comb begin
      merged    = req_addr | base;
      trim_addr = req_pass ? merged  : {merged[AW-1:1], 1'b0};
      trim_len  = req_pass ? req_len : {req_len[LW-1:1], 1'b0};
      zero_len  = (trim_len == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
         wr_q   <= 1'b0;
         pass_q <= 1'b1;
      end else if (load) begin
         addr_q <= trim_addr;
         rem_q  <= trim_len;
         wr_q   <= req_wr;
         pass_q <= req_pass;
      end else if (advance) begin
         addr_q <= addr_q + AW'(chunk_len);
         rem_q  <= rem_q - chunk_len;
      end
   end

   // only swapped writes are bounded; everything else is one burst
   always_comb begin
      split      = wr_q && !pass_q && (rem_q > CHUNK_L);
      chunk_len  = split ? CHUNK_L : rem_q;
      last_chunk = !split;
      cur_addr   = addr_q;
   end

endmodule

// File: rtl/hsdma_swap_lane.sv
module hsdma_swap_lane #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          swap,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_byte,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_byte
);

   logic [DW-1:0] hold_lo;
   logic [DW-1:0] hold_hi;
   logic          have_lo;
   logic          draining;
   logic          tail;
   logic          in_fire;
   logic          out_fire;

   assign in_ready  = en && !draining;
   assign out_valid = draining;
   assign out_byte  = tail ? hold_lo : hold_hi;
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;

   // pass mode: one byte in, same byte out
   // swap mode: two bytes in, emitted high-then-low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_lo  <= '0;
         hold_hi  <= '0;
         have_lo  <= 1'b0;
         draining <= 1'b0;
         tail     <= 1'b0;
      end else if (in_fire) begin
         if (!swap) begin
            hold_lo  <= in_byte;
            draining <= 1'b1;
            tail     <= 1'b1;
         end else if (!have_lo) begin
            hold_lo <= in_byte;
            have_lo <= 1'b1;
         end else begin
            hold_hi  <= in_byte;
            have_lo  <= 1'b0;
            draining <= 1'b1;
            tail     <= 1'b0;
         end
      end else if (out_fire) begin
         if (tail) begin
            draining <= 1'b0;
         end else begin
            tail <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hsdma_ctrl.sv
module hsdma_ctrl
   import hsdma_pkg::*;
#(
   parameter int LW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   output logic          load,
   input  logic          zero_len,
   output logic          cmd_valid,
   input  logic          cmd_ready,
   input  logic [LW-1:0] chunk_len,
   input  logic          last_chunk,
   output logic          in_en,
   input  logic          in_fire,
   input  logic          out_fire,
   output logic          advance,
   output logic          done
);

   hsdma_state_e st, st_nx;
   logic [LW-1:0] in_cnt;
   logic [LW-1:0] out_cnt;
   logic          out_last;

   assign req_ready = (st == ST_IDLE);
   assign load      = req_valid && req_ready;
   assign cmd_valid = (st == ST_CMD);
   assign in_en     = (st == ST_DATA) && (in_cnt != chunk_len);
   assign out_last  = out_fire && ((out_cnt + LW'(1)) == chunk_len);
   assign advance   = (st == ST_DATA) && out_last;
   assign done      = (st == ST_FIN);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (load)      st_nx = zero_len ? ST_FIN : ST_CMD;
         ST_CMD:  if (cmd_ready) st_nx = ST_DATA;
         ST_DATA: if (out_last)  st_nx = last_chunk ? ST_FIN : ST_CMD;
         ST_FIN:                 st_nx = ST_IDLE;
         default:                st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         in_cnt  <= '0;
         out_cnt <= '0;
      end else begin
         st <= st_nx;
         if (st == ST_CMD) begin
            in_cnt  <= '0;
            out_cnt <= '0;
         end else if (st == ST_DATA) begin
            if (in_fire)  in_cnt  <= in_cnt + LW'(1);
            if (out_fire) out_cnt <= out_cnt + LW'(1);
         end
      end
   end

endmodule

// File: rtl/hsdma_path.sv
module hsdma_path #(
   parameter int AW    = 32,
   parameter int LW    = 16,
   parameter int CHUNK = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cfg_base,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   input  logic          req_wr,
   input  logic          req_pass,
   input  logic          wdat_valid,
   output logic          wdat_ready,
   input  logic [7:0]    wdat_byte,
   output logic          rd_valid,
   input  logic          rd_ready,
   output logic [7:0]    rd_byte,
   output logic          mem_cmd_valid,
   input  logic          mem_cmd_ready,
   output logic [AW-1:0] mem_cmd_addr,
   output logic [LW-1:0] mem_cmd_len,
   output logic          mem_cmd_wr,
   output logic          mem_wvalid,
   input  logic          mem_wready,
   output logic [7:0]    mem_wdata,
   input  logic          mem_rvalid,
   output logic          mem_rready,
   input  logic [7:0]    mem_rdata,
   output logic          done
);

   generate
      if (CHUNK < 2 || (CHUNK % 2) != 0) begin : g_bad_chunk
         $error("CHUNK must be an even value of at least 2");
      end
      if (LW < 2 || LW > 31 || CHUNK >= (1 << LW)) begin : g_bad_len
         $error("LW must be 2..31 and wide enough to hold CHUNK");
      end
      if (AW < 2) begin : g_bad_addr
         $error("AW must be at least 2");
      end
   endgenerate

   logic          load, zero_len, advance, last_chunk;
   logic          wr_q, pass_q, in_en;
   logic [LW-1:0] chunk_len;
   logic          ln_in_valid, ln_in_ready, ln_out_valid, ln_out_ready;
   logic [7:0]    ln_in_byte, ln_out_byte;
   logic          in_fire, out_fire;

   hsdma_addr_gen #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .base       (cfg_base),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_wr     (req_wr),
      .req_pass   (req_pass),
      .advance    (advance),
      .zero_len   (zero_len),
      .cur_addr   (mem_cmd_addr),
      .chunk_len  (chunk_len),
      .last_chunk (last_chunk),
      .wr_q       (wr_q),
      .pass_q     (pass_q)
   );

   hsdma_ctrl #(.LW(LW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .load       (load),
      .zero_len   (zero_len),
      .cmd_valid  (mem_cmd_valid),
      .cmd_ready  (mem_cmd_ready),
      .chunk_len  (chunk_len),
      .last_chunk (last_chunk),
      .in_en      (in_en),
      .in_fire    (in_fire),
      .out_fire   (out_fire),
      .advance    (advance),
      .done       (done)
   );

   // direction steering around a single byte lane
   always_comb begin
      ln_in_valid  = wr_q ? wdat_valid : mem_rvalid;
      ln_in_byte   = wr_q ? wdat_byte  : mem_rdata;
      ln_out_ready = wr_q ? mem_wready : rd_ready;
      wdat_ready   = ln_in_ready &&  wr_q;
      mem_rready   = ln_in_ready && !wr_q;
      mem_wvalid   = ln_out_valid &&  wr_q;
      rd_valid     = ln_out_valid && !wr_q;
      mem_wdata    = ln_out_byte;
      rd_byte      = ln_out_byte;
      in_fire      = ln_in_valid && ln_in_ready;
      out_fire     = ln_out_valid && ln_out_ready;
   end

   assign mem_cmd_len = chunk_len;
   assign mem_cmd_wr  = wr_q;

   hsdma_swap_lane #(.DW(8)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (in_en),
      .swap      (!pass_q),
      .in_valid  (ln_in_valid),
      .in_ready  (ln_in_ready),
      .in_byte   (ln_in_byte),
      .out_valid (ln_out_valid),
      .out_ready (ln_out_ready),
      .out_byte  (ln_out_byte)
   );

endmodule

// File: rtl/hsdma_path_chk.sv
module hsdma_path_chk #(
   parameter int AW    = 32,
   parameter int LW    = 16,
   parameter int CHUNK = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_pass,
   input logic          mem_cmd_valid,
   input logic          mem_cmd_ready,
   input logic [AW-1:0] mem_cmd_addr,
   input logic [LW-1:0] mem_cmd_len,
   input logic          mem_cmd_wr,
   input logic          mem_wvalid,
   input logic          rd_valid,
   input logic          done
);

   logic pass_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pass_seen <= 1'b1;
      else if (req_valid && req_ready) pass_seen <= req_pass;
   end

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len)); // R1
   AST_SWAP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid && !pass_seen |-> !mem_cmd_addr[0] && !mem_cmd_len[0]); // R3
   AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid && mem_cmd_wr && !pass_seen |-> mem_cmd_len <= LW'(CHUNK)); // R6
   AST_NO_EMPTY_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmd_valid |-> mem_cmd_len != '0); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cmd_valid || mem_wvalid || rd_valid || done) |-> !req_ready); // R10

endmodule

bind hsdma_path hsdma_path_chk #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_pass      (req_pass),
   .mem_cmd_valid (mem_cmd_valid),
   .mem_cmd_ready (mem_cmd_ready),
   .mem_cmd_addr  (mem_cmd_addr),
   .mem_cmd_len   (mem_cmd_len),
   .mem_cmd_wr    (mem_cmd_wr),
   .mem_wvalid    (mem_wvalid),
   .rd_valid      (rd_valid),
   .done          (done)
);

// File: tb/sim_hsdma_path.sv
module sim_hsdma_path;

   localparam int AW = 32;
   localparam int LW = 16;
   localparam int CHUNK = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic          req_valid = 1'b0, req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          req_wr = 1'b0, req_pass = 1'b1;
   logic          wdat_valid, wdat_ready;
   logic [7:0]    wdat_byte;
   logic          rd_valid, rd_ready = 1'b1;
   logic [7:0]    rd_byte;
   logic          mem_cmd_valid, mem_cmd_ready;
   logic [AW-1:0] mem_cmd_addr;
   logic [LW-1:0] mem_cmd_len;
   logic          mem_cmd_wr;
   logic          mem_wvalid, mem_wready = 1'b1;
   logic [7:0]    mem_wdata;
   logic          mem_rvalid, mem_rready;
   logic [7:0]    mem_rdata;
   logic          done;

   always #10 clk = ~clk;   // 50 MHz

   hsdma_path #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u0 (.*);

   int nchk = 0, nfail = 0;
   int cyc = 0;
   int cmd_n = 0, wn = 0, rn = 0, done_n = 0;
   int rsent = 0, rtotal = 0, wsent = 0, wtotal = 0;
   int done_cyc = 0, last_cyc = 0, acc_cyc = 0, busy_ready = 0;
   logic [AW-1:0] rec_addr [0:15];
   logic [LW-1:0] rec_len  [0:15];
   logic [7:0]    wbuf [0:255];
   logic [7:0]    rbuf [0:255];

   // recorder: samples handshakes at the rising edge
   always @(posedge clk) begin
      cyc++;
      if (req_valid && req_ready) acc_cyc = cyc;
      if (mem_cmd_valid && req_ready) busy_ready++;
      if (mem_cmd_valid && mem_cmd_ready) begin
         if (cmd_n < 16) begin
            rec_addr[cmd_n] = mem_cmd_addr;
            rec_len[cmd_n]  = mem_cmd_len;
         end
         cmd_n++;
         if (!mem_cmd_wr) rtotal += int'(mem_cmd_len);
      end
      if (mem_wvalid && mem_wready) begin
         if (wn < 256) wbuf[wn] = mem_wdata;
         wn++;
         last_cyc = cyc;
      end
      if (rd_valid && rd_ready) begin
         if (rn < 256) rbuf[rn] = rd_byte;
         rn++;
         last_cyc = cyc;
      end
      if (mem_rvalid && mem_rready) rsent++;
      if (wdat_valid && wdat_ready) wsent++;
      if (done) begin
         done_n++;
         done_cyc = cyc;
      end
   end

   // models: drive on the falling edge
   always @(negedge clk) begin
      mem_cmd_ready = (cyc % 3) != 0;
      mem_rvalid    = rsent < rtotal;
      mem_rdata     = 8'(8'h40 + rsent);
      wdat_valid    = wsent < wtotal;
      wdat_byte     = 8'(8'h10 + wsent);
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // issue one request, wait for done, check bursts, data and timing
   task automatic run(input string tag, input logic [AW-1:0] base,
                      input logic [AW-1:0] addr, input int len,
                      input bit wr, input bit pass);
      int elen, ncmd, t, d0, bad, first_bad;
      logic [AW-1:0] ea;
      logic [7:0] expb, gotb;
      elen = pass ? len : (len & ~1);
      ea   = (addr | base) & (pass ? '1 : ~AW'(1));
      ncmd = (elen == 0) ? 0 : ((wr && !pass) ? (elen + CHUNK - 1) / CHUNK : 1);
      @(negedge clk);
      cmd_n = 0; wn = 0; rn = 0; rsent = 0; rtotal = 0; wsent = 0;
      wtotal = wr ? elen : 0;
      cfg_base = base; req_addr = addr; req_len = LW'(len);
      req_wr = wr; req_pass = pass; req_valid = 1'b1;
      @(posedge clk);
      while (!req_ready) @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      d0 = done_n;
      t = 0;
      while (done_n == d0 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      chk(done_n == d0 + 1, "R9", {tag, " done pulse count"}, done_n - d0, 1);
      chk(cmd_n == ncmd, tag, "burst count", cmd_n, ncmd);
      for (int k = 0; k < ncmd && k < 16; k++) begin
         int exl;
         exl = (wr && !pass) ? ((elen - k*CHUNK > CHUNK) ? CHUNK : elen - k*CHUNK) : elen;
         chk(rec_addr[k] == ea + AW'(k*CHUNK), tag, "burst address", rec_addr[k], ea + AW'(k*CHUNK));
         chk(int'(rec_len[k]) == exl, tag, "burst length", rec_len[k], exl);
      end
      chk((wr ? wn : rn) == elen, tag, "byte count", wr ? wn : rn, elen);
      bad = 0; first_bad = 0;
      for (int i = 0; i < elen && i < 256; i++) begin
         expb = 8'((wr ? 8'h10 : 8'h40) + (pass ? i : (i ^ 1)));
         gotb = wr ? wbuf[i] : rbuf[i];
         if (gotb != expb) begin
            if (bad == 0) first_bad = i;
            bad++;
         end
      end
      chk(bad == 0, tag, "data order", bad, 0);
      if (bad != 0) $display("  first mismatch at byte %0d", first_bad);
      if (elen == 0)
         chk(done_cyc == acc_cyc + 1, "R8", "done after empty accept", done_cyc, acc_cyc + 1);
      else
         chk(done_cyc == last_cyc + 1, "R9", "done after last byte", done_cyc, last_cyc + 1);
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R11", "req_ready after reset", req_ready, 1);
      chk(mem_cmd_valid == 1'b0, "R11", "mem_cmd_valid after reset", mem_cmd_valid, 0);
      chk(mem_wvalid == 1'b0 && rd_valid == 1'b0, "R11", "data valid after reset", mem_wvalid | rd_valid, 0);
      chk(done == 1'b0, "R11", "done after reset", done, 0);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      // R1 R2 R7: pass write keeps odd address, OR merge
      run("R2", 32'h2000_0000, 32'h0000_1001, 5, 1'b1, 1'b1);
      // R1: overlapping bits show OR, not add (0x131|0x110 -> 0x130 after trim)
      run("R1", 32'h0000_0110, 32'h0000_0131, 6, 1'b1, 1'b0);
      // R3 R4: swap write trims odd address and length
      run("R4", 32'h00F0_0000, 32'h0000_0103, 9, 1'b1, 1'b0);
      // R6: swap write split into 64, 64, 22
      run("R6", 32'h0000_0000, 32'h0000_0200, 150, 1'b1, 1'b0);
      // R7: pass write stays one burst
      run("R7", 32'h0000_0000, 32'h0000_0200, 150, 1'b1, 1'b1);
      // R5: swap read
      run("R5", 32'h0000_0110, 32'h0000_0131, 7, 1'b0, 1'b0);
      run("R5", 32'h1000_0000, 32'h0000_0040, 200, 1'b0, 1'b0);
      // R2: pass read odd length
      run("R2", 32'h0000_0001, 32'h0000_0010, 3, 1'b0, 1'b1);
      // R8: length trims to zero, and a true zero
      run("R8", 32'h0000_0000, 32'h0000_0021, 1, 1'b1, 1'b0);
      run("R8", 32'h0000_0000, 32'h0000_0020, 0, 1'b0, 1'b1);
      // R3: exact chunk multiple
      run("R3", 32'h0000_0000, 32'h0000_0401, 129, 1'b1, 1'b0);
      chk(busy_ready == 0, "R10", "req_ready while burst pending", busy_ready, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule